// File: doc/BRIEF.md
# Serial Flash Erase and Page-Program Sequencer

This block runs one complete modifying transaction on a serial NOR flash attached over SPI. A host presents an operation code, a sector number and a page number, and raises a pending flag. The block captures these values and opens a write-enable frame. It then sends the erase or program command with its address. It polls the flash status register until the internal program cycle ends, and closes with a write-disable frame. Two handshake flags report progress back to the host. For a page program the payload is pulled from a byte-wide input, and a strobe tells the host to present the next byte.

Operations the block does not carry out are turned away through the error path, and the bus stays untouched. A flash that stays busy for too long also ends in the error path, and that path skips the write-disable frame. The host ends every operation by dropping the pending flag. Both flags then clear.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset spiCsN is 1, spiSck is 0, and opAttended and opFinished are both 0. While both flags are 0, spiCsN stays 1.
- R2: When opPending is 1 in idle, opAttended reads 1 after the next clock edge. opCode, sectorNum and pageNum are captured at that edge, and later changes to them have no effect on the running operation.
- R3: A valid operation (opCode 2'b01 = erase sector, 2'b11 = program page) starts with a frame that carries only the byte 0x06.
- R4: The second frame carries the command byte (0xD8 for erase, 0x02 for program) and then three address bytes. The 24-bit address is {2'b00, sector[5:0], page[7:0], 8'h00}, sent most significant byte first. An erase frame holds exactly 4 bytes.
- R5: A program frame holds 4 + PAGE_BYTES bytes. The payload bytes are the successive values of pageData, in order. pageDataNext is 1 for exactly one cycle per payload byte, and is never 1 during an erase.
- R6: After the command frame the block sends status-poll frames. Each poll frame is 0x05 followed by one byte clocked in from spiMiso. If bit 0 of that byte is 1 (busy), another poll frame follows. If it is 0, polling stops.
- R7: After a poll reports not busy, a frame carrying only 0x04 is sent. Then opFinished is 1 and opAttended is 0.
- R8: If POLL_LIMIT poll frames in a row report busy, the block stops after the last of them and sends no 0x04 frame. Both flags then read 1.
- R9: opCode 2'b00 or 2'b10 drives no frame at all and sets both flags to 1 at the edge where the operation is taken.
- R10: After an operation ends, no new operation starts while opPending stays 1. Both flags read 0 one clock edge after opPending falls.
- R11: SPI mode 0. spiSck idles low and is never high while spiCsN is 1. Each byte is sent MSB first, and MISO is sampled at the rising spiSck edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opPending | input | 1 | Operation request, held until the host has seen the end |
| opCode | input | 2 | 01 erase sector, 11 program page, 00/10 rejected |
| sectorNum | input | SECTOR_W | Sector number |
| pageNum | input | PAGE_W | Page number |
| pageData | input | 8 | Current payload byte for a page program |
| pageDataNext | output | 1 | Payload byte taken at this edge; present the next one |
| opAttended | output | 1 | Operation taken (held on error) |
| opFinished | output | 1 | Operation ended |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
The hardest condition to reach from the ports is the poll timeout, and next to it the run that stops one poll short of the timeout. Both depend on what the flash answers, several frames deep into the transaction. The bench contains a small flash model that decodes each frame as it is clocked in. The model answers status polls from a per-test count of busy replies. That count is set to zero, to a few replies, to POLL_LIMIT-1 and to at least POLL_LIMIT, which drives the block into each ending. A further test drops the pending flag in the middle of an operation, and checks that the transaction still completes and that the flags then clear.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_RSVD  = 2'b00,
    OP_ERASE = 2'b01,
    OP_READ  = 2'b10,
    OP_PROG  = 2'b11
  } flashOp_e;

  localparam logic [7:0] CMD_WR_ENABLE  = 8'h06;
  localparam logic [7:0] CMD_WR_DISABLE = 8'h04;
  localparam logic [7:0] CMD_READ_STAT  = 8'h05;
  localparam logic [7:0] CMD_SECT_ERASE = 8'hD8;
  localparam logic [7:0] CMD_PAGE_PROG  = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WREN, ST_CMD, ST_POLL, ST_WRDI, ST_DONE, ST_ERROR
  } seqState_e;

  typedef enum logic [1:0] {
    PH_OPEN, PH_SEND, PH_WAIT, PH_CLOSE
  } framePhase_e;

  // control to datapath strobes
  typedef struct packed {
    logic       csOpen;
    logic       csClose;
    logic       send;
    logic [7:0] txByte;
  } spiStrobe_t;

endpackage

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter
  import flash_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  spiStrobe_t strobe,
  output logic       byteDone,
  output logic       rxBit0,
  output logic       spiCsN,
  output logic       spiSck,
  output logic       spiMosi,
  input  logic       spiMiso
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [7:0]       shiftQ;
  logic [7:0]       rxQ;
  logic [2:0]       bitQ;
  logic [DIV_W-1:0] divQ;
  logic             busyQ;
  logic             sckQ;
  logic             csNQ;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
      rxQ    <= '0;
      bitQ   <= '0;
      divQ   <= '0;
      busyQ  <= 1'b0;
      sckQ   <= 1'b0;
      csNQ   <= 1'b1;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.csOpen) begin
        csNQ <= 1'b0;
      end else if (strobe.csClose) begin
        csNQ <= 1'b1;
      end
      if (strobe.send) begin
        shiftQ <= strobe.txByte;
        busyQ  <= 1'b1;
        bitQ   <= '0;
        divQ   <= '0;
        sckQ   <= 1'b0;
      end else if (busyQ) begin
        if (divQ == DIV_LAST) begin
          divQ <= '0;
          if (!sckQ) begin
            sckQ <= 1'b1;
            rxQ  <= {rxQ[6:0], spiMiso};
          end else begin
            sckQ   <= 1'b0;
            shiftQ <= {shiftQ[6:0], 1'b0};
            if (bitQ == 3'd7) begin
              busyQ <= 1'b0;
              doneQ <= 1'b1;
            end else begin
              bitQ <= bitQ + 3'd1;
            end
          end
        end else begin
          divQ <= divQ + DIV_W'(1);
        end
      end
    end
  end

  assign byteDone = doneQ;
  assign rxBit0   = rxQ[0];
  assign spiCsN   = csNQ;
  assign spiSck   = sckQ;
  assign spiMosi  = shiftQ[7];

  // R11: clock stays low while the flash is deselected
  p_sck_low_deselected_r11: assert property (@(posedge clk) disable iff (rst)
    csNQ |-> !sckQ);

  // R11: a byte is only launched into a selected flash
  p_send_selected_r11: assert property (@(posedge clk) disable iff (rst)
    strobe.send |-> !csNQ);

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int POLL_LIMIT = 50000,
  parameter int SECTOR_W   = 6,
  parameter int PAGE_W     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                opPending,
  input  logic [1:0]          opCode,
  input  logic [SECTOR_W-1:0] sectorNum,
  input  logic [PAGE_W-1:0]   pageNum,
  input  logic [7:0]          pageData,
  output logic                pageDataNext,
  output logic                opAttended,
  output logic                opFinished,
  output spiStrobe_t          strobe,
  input  logic                byteDone,
  input  logic                rxBit0
);

  localparam int IDX_W  = $clog2(PAGE_BYTES + 4);
  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
  localparam logic [IDX_W-1:0]  PROG_LAST = IDX_W'(PAGE_BYTES + 3);

  seqState_e           stateQ;
  framePhase_e         phaseQ;
  logic [IDX_W-1:0]    idxQ;
  logic [POLL_W-1:0]   pollQ;
  flashOp_e            opQ;
  logic [SECTOR_W-1:0] sectorQ;
  logic [PAGE_W-1:0]   pageQ;
  logic                attendQ;
  logic                finishQ;

  logic [23:0]         flashAddr;
  logic [IDX_W-1:0]    frameLast;
  logic [7:0]          curByte;
  logic                inFrame;

  assign flashAddr = 24'({sectorQ, pageQ, 8'h00});
  assign inFrame   = (stateQ == ST_WREN) || (stateQ == ST_CMD) ||
                     (stateQ == ST_POLL) || (stateQ == ST_WRDI);

  always_comb begin
    frameLast = '0;
    curByte   = 8'h00;
    case (stateQ)
      ST_WREN: curByte = CMD_WR_ENABLE;
      ST_WRDI: curByte = CMD_WR_DISABLE;
      ST_POLL: begin
        frameLast = IDX_W'(1);
        curByte   = (idxQ == '0) ? CMD_READ_STAT : 8'h00;
      end
      ST_CMD: begin
        frameLast = (opQ == OP_PROG) ? PROG_LAST : IDX_W'(3);
        case (idxQ)
          IDX_W'(0): curByte = (opQ == OP_PROG) ? CMD_PAGE_PROG : CMD_SECT_ERASE;
          IDX_W'(1): curByte = flashAddr[23:16];
          IDX_W'(2): curByte = flashAddr[15:8];
          IDX_W'(3): curByte = flashAddr[7:0];
          default:   curByte = pageData;
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    strobe.csOpen  = inFrame && (phaseQ == PH_OPEN);
    strobe.send    = inFrame && (phaseQ == PH_SEND);
    strobe.csClose = inFrame && (phaseQ == PH_CLOSE);
    strobe.txByte  = curByte;
  end

  assign pageDataNext = (stateQ == ST_CMD) && (phaseQ == PH_SEND) &&
                        (idxQ >= IDX_W'(4));
  assign opAttended   = attendQ;
  assign opFinished   = finishQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      phaseQ  <= PH_OPEN;
      idxQ    <= '0;
      pollQ   <= '0;
      opQ     <= OP_RSVD;
      sectorQ <= '0;
      pageQ   <= '0;
      attendQ <= 1'b0;
      finishQ <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (opPending) begin
            opQ     <= flashOp_e'(opCode);
            sectorQ <= sectorNum;
            pageQ   <= pageNum;
            attendQ <= 1'b1;
            phaseQ  <= PH_OPEN;
            pollQ   <= '0;
            if (opCode == OP_ERASE || opCode == OP_PROG) begin
              stateQ <= ST_WREN;
            end else begin
              stateQ  <= ST_ERROR;
              finishQ <= 1'b1;
            end
          end
        end
        ST_DONE, ST_ERROR: begin
          if (!opPending) begin
            stateQ  <= ST_IDLE;
            attendQ <= 1'b0;
            finishQ <= 1'b0;
          end
        end
        default: begin
          case (phaseQ)
            PH_OPEN: begin
              phaseQ <= PH_SEND;
              idxQ   <= '0;
            end
            PH_SEND: phaseQ <= PH_WAIT;
            PH_WAIT: begin
              if (byteDone) begin
                if (idxQ == frameLast) begin
                  phaseQ <= PH_CLOSE;
                end else begin
                  idxQ   <= idxQ + IDX_W'(1);
                  phaseQ <= PH_SEND;
                end
              end
            end
            default: begin
              phaseQ <= PH_OPEN;
              case (stateQ)
                ST_WREN: stateQ <= ST_CMD;
                ST_CMD: begin
                  stateQ <= ST_POLL;
                  pollQ  <= '0;
                end
                ST_POLL: begin
                  if (!rxBit0) begin
                    stateQ <= ST_WRDI;
                  end else if (pollQ == POLL_LAST) begin
                    stateQ  <= ST_ERROR;
                    finishQ <= 1'b1;
                  end else begin
                    pollQ <= pollQ + POLL_W'(1);
                  end
                end
                ST_WRDI: begin
                  stateQ  <= ST_DONE;
                  attendQ <= 1'b0;
                  finishQ <= 1'b1;
                end
                default: begin
                  stateQ  <= ST_ERROR;
                  finishQ <= 1'b1;
                end
              endcase
            end
          endcase
        end
      endcase
    end
  end

  // R2: a pending request in idle is attended at the next edge
  p_take_attends_r2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && opPending) |=> opAttended);

  // R8: the failure state shows both flags
  p_error_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ERROR) |-> (attendQ && finishQ));

  // R7: a successful end shows finished without attended
  p_done_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_DONE) |-> (!attendQ && finishQ));

  // R10: dropping the request clears both flags at the next edge
  p_release_clears_r10: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == ST_DONE || stateQ == ST_ERROR) && !opPending)
      |=> (!opAttended && !opFinished));

  // R5: payload is only pulled for a page program
  p_payload_program_r5: assert property (@(posedge clk) disable iff (rst)
    pageDataNext |-> (opQ == OP_PROG));

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_LIMIT = 50000,
  parameter int SECTOR_W   = 6,
  parameter int PAGE_W     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                opPending,
  input  logic [1:0]          opCode,
  input  logic [SECTOR_W-1:0] sectorNum,
  input  logic [PAGE_W-1:0]   pageNum,
  input  logic [7:0]          pageData,
  output logic                pageDataNext,
  output logic                opAttended,
  output logic                opFinished,
  output logic                spiCsN,
  output logic                spiSck,
  output logic                spiMosi,
  input  logic                spiMiso
);

  spiStrobe_t strobe;
  logic       byteDone;
  logic       rxBit0;

  flash_seq_ctrl #(
    .PAGE_BYTES (PAGE_BYTES),
    .POLL_LIMIT (POLL_LIMIT),
    .SECTOR_W   (SECTOR_W),
    .PAGE_W     (PAGE_W)
  ) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .opPending    (opPending),
    .opCode       (opCode),
    .sectorNum    (sectorNum),
    .pageNum      (pageNum),
    .pageData     (pageData),
    .pageDataNext (pageDataNext),
    .opAttended   (opAttended),
    .opFinished   (opFinished),
    .strobe       (strobe),
    .byteDone     (byteDone),
    .rxBit0       (rxBit0)
  );

  flash_spi_shifter #(
    .HALF_DIV (HALF_DIV)
  ) i_shifter (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .byteDone (byteDone),
    .rxBit0   (rxBit0),
    .spiCsN   (spiCsN),
    .spiSck   (spiSck),
    .spiMosi  (spiMosi),
    .spiMiso  (spiMiso)
  );

  // R1: with no operation in hand the flash stays deselected
  p_idle_deselected_r1: assert property (@(posedge clk) disable iff (rst)
    (!opAttended && !opFinished) |-> spiCsN);

endmodule

// File: tb/test_flash_op_sequencer.sv
module test_flash_op_sequencer;

  localparam int PAGE  = 256;
  localparam int LIMIT = 6;
  localparam int NVEC  = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       opPending = 1'b0;
  logic [1:0] opCode = 2'b00;
  logic [5:0] sectorNum = '0;
  logic [7:0] pageNum = '0;
  logic [7:0] pageData = '0;
  logic       pageDataNext;
  logic       opAttended;
  logic       opFinished;
  logic       spiCsN;
  logic       spiSck;
  logic       spiMosi;
  logic       spiMiso;

  flash_op_sequencer #(
    .HALF_DIV   (2),
    .PAGE_BYTES (PAGE),
    .POLL_LIMIT (LIMIT),
    .SECTOR_W   (6),
    .PAGE_W     (8)
  ) i_flash_op_sequencer (
    .clk          (clk),
    .rst          (rst),
    .opPending    (opPending),
    .opCode       (opCode),
    .sectorNum    (sectorNum),
    .pageNum      (pageNum),
    .pageData     (pageData),
    .pageDataNext (pageDataNext),
    .opAttended   (opAttended),
    .opFinished   (opFinished),
    .spiCsN       (spiCsN),
    .spiSck       (spiSck),
    .spiMosi      (spiMosi),
    .spiMiso      (spiMiso)
  );

  initial forever #2 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit summaryDone = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // ---------------- flash model ----------------
  int         frameCount;
  logic [7:0] frameOp [16];
  int         frameLen [16];
  logic [7:0] addrB [3];
  int         dataErrs;
  int         rdsrSeen;
  int         busyPolls;
  int         sckDeselected;
  int         curBits;
  int         curBytes;
  logic [7:0] curSr;
  logic [7:0] curFirst;
  int         dataIdx;
  int         dataTakes;
  logic [7:0] statusNow;
  logic [2:0] bitPos;

  function automatic logic [7:0] pattern(input int i);
    return 8'(i * 37 + 11);
  endfunction

  assign statusNow = (rdsrSeen < busyPolls) ? 8'h03 : 8'h02;
  assign bitPos    = 3'(curBits);
  assign spiMiso   = (!spiCsN && curFirst == 8'h05 && curBytes == 1) ?
                     statusNow[3'd7 - bitPos] : 1'b0;

  initial forever begin
    @(negedge spiCsN);
    curBits  = 0;
    curBytes = 0;
  end

  initial forever begin
    @(posedge spiSck);
    if (spiCsN) begin
      sckDeselected++;
    end else begin
      curSr = {curSr[6:0], spiMosi};
      curBits++;
      if (curBits % 8 == 0) begin
        if (curBytes == 0) begin
          curFirst = curSr;
        end else if ((curFirst == 8'hD8 || curFirst == 8'h02) && curBytes <= 3) begin
          addrB[curBytes-1] = curSr;
        end else if (curFirst == 8'h02 && curBytes >= 4) begin
          if (curSr != pattern(curBytes - 4)) dataErrs++;
        end
        curBytes++;
      end
    end
  end

  initial forever begin
    @(posedge spiCsN);
    if (frameCount < 16) begin
      frameOp[frameCount]  = curFirst;
      frameLen[frameCount] = curBytes;
    end
    frameCount++;
    if (curFirst == 8'h05 && curBytes > 0) rdsrSeen++;
  end

  // payload supplier: advance one byte after each edge that took one
  initial forever begin
    bit take;
    @(negedge clk);
    take = pageDataNext;
    @(posedge clk);
    #1;
    if (take) begin
      dataIdx++;
      dataTakes++;
      pageData = pattern(dataIdx);
    end
  end

  task automatic modelClear(input int busy);
    frameCount    = 0;
    dataErrs      = 0;
    rdsrSeen      = 0;
    busyPolls     = busy;
    sckDeselected = 0;
    dataIdx       = 0;
    dataTakes     = 0;
    pageData      = pattern(0);
    for (int k = 0; k < 16; k++) begin
      frameOp[k]  = 8'h00;
      frameLen[k] = 0;
    end
    for (int k = 0; k < 3; k++) addrB[k] = 8'h00;
  endtask

  // ---------------- stimulus table ----------------
  // fields: op[24:23] sector[22:17] page[16:9] busyReplies[8:1] expectError[0]
  localparam logic [24:0] VEC [NVEC] = '{
    {2'b01, 6'h2A, 8'h5C, 8'd0, 1'b0},
    {2'b01, 6'h3F, 8'hFF, 8'd3, 1'b0},
    {2'b11, 6'h01, 8'h80, 8'd2, 1'b0},
    {2'b00, 6'h15, 8'h33, 8'd0, 1'b1},
    {2'b10, 6'h00, 8'h01, 8'd0, 1'b1},
    {2'b01, 6'h00, 8'h00, 8'd5, 1'b0},
    {2'b01, 6'h10, 8'h20, 8'd6, 1'b1},
    {2'b11, 6'h3E, 8'h7F, 8'd9, 1'b1}
  };

  task automatic runVector(input logic [24:0] v);
    logic [1:0] op;
    logic [5:0] sec;
    logic [7:0] pg;
    int busy, expFrames, lastIdx, waitCnt, framesHeld;
    bit expErr, badOp, isProg, timeout;
    op     = v[24:23];
    sec    = v[22:17];
    pg     = v[16:9];
    busy   = int'(v[8:1]);
    expErr = v[0];
    badOp  = (op == 2'b00 || op == 2'b10);
    isProg = (op == 2'b11);
    timeout = !badOp && (busy >= LIMIT);
    expFrames = badOp ? 0 : (timeout ? 2 + LIMIT : busy + 4);

    modelClear(busy);
    @(negedge clk);
    opCode = op; sectorNum = sec; pageNum = pg; opPending = 1'b1;
    @(negedge clk);
    check(opAttended == 1'b1, "R2 attended after take", int'(opAttended), 1);
    check(opFinished == badOp, "R9 finished at take", int'(opFinished), int'(badOp));
    // operands changed after capture must not matter (R2)
    opCode = ~op; sectorNum = ~sec; pageNum = ~pg;

    waitCnt = 0;
    while (!opFinished && waitCnt < 40000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(opFinished == 1'b1, "R7 finished reached", int'(opFinished), 1);
    check(opAttended == expErr, "R8 attended at end", int'(opAttended), int'(expErr));
    check(frameCount == expFrames, "R6 frame count", frameCount, expFrames);

    if (!badOp && frameCount == expFrames) begin
      check(frameOp[0] == 8'h06 && frameLen[0] == 1, "R3 enable frame",
            int'(frameOp[0]), 32'h06);
      check(frameOp[1] == (isProg ? 8'h02 : 8'hD8), "R4 command byte",
            int'(frameOp[1]), isProg ? 32'h02 : 32'hD8);
      check(frameLen[1] == (isProg ? PAGE + 4 : 4), "R5 command length",
            frameLen[1], isProg ? PAGE + 4 : 4);
      check(addrB[0] == {2'b00, sec}, "R4 address high", int'(addrB[0]), int'({2'b00, sec}));
      check(addrB[1] == pg, "R4 address mid", int'(addrB[1]), int'(pg));
      check(addrB[2] == 8'h00, "R4 address low", int'(addrB[2]), 0);
      lastIdx = expFrames - 1;
      for (int k = 2; k < (timeout ? expFrames : lastIdx); k++) begin
        check(frameOp[k] == 8'h05 && frameLen[k] == 2, "R6 poll frame",
              int'(frameOp[k]), 32'h05);
      end
      if (timeout) begin
        check(frameOp[lastIdx] == 8'h05, "R8 no disable after timeout",
              int'(frameOp[lastIdx]), 32'h05);
      end else begin
        check(frameOp[lastIdx] == 8'h04 && frameLen[lastIdx] == 1, "R7 disable frame",
              int'(frameOp[lastIdx]), 32'h04);
      end
    end
    check(dataTakes == (isProg ? PAGE : 0), "R5 payload strobes", dataTakes,
          isProg ? PAGE : 0);
    check(dataErrs == 0, "R5 payload bytes", dataErrs, 0);

    framesHeld = frameCount;
    repeat (60) @(negedge clk);
    check(frameCount == framesHeld && opFinished, "R10 no restart while pending",
          frameCount, framesHeld);
    opPending = 1'b0;
    @(negedge clk);
    check(!opAttended && !opFinished, "R10 flags clear",
          int'({opAttended, opFinished}), 0);
    check(sckDeselected == 0 && spiCsN && !spiSck, "R11 clock idle", sckDeselected, 0);
  endtask

  initial begin
    modelClear(0);
    curFirst = 8'h00;
    curSr    = 8'h00;
    curBits  = 0;
    curBytes = 0;
    repeat (4) @(negedge clk);
    check(spiCsN == 1'b1 && spiSck == 1'b0, "R1 bus after reset",
          int'({spiCsN, spiSck}), 2);
    check(!opAttended && !opFinished, "R1 flags after reset",
          int'({opAttended, opFinished}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(spiCsN == 1'b1, "R1 idle deselected", int'(spiCsN), 1);

    for (int i = 0; i < NVEC; i++) begin
      runVector(VEC[i]);
      repeat (3) @(negedge clk);
    end

    // request withdrawn while an erase is running: it still completes (R7, R10)
    modelClear(1);
    @(negedge clk);
    opCode = 2'b01; sectorNum = 6'h05; pageNum = 8'h06; opPending = 1'b1;
    @(negedge clk);
    opPending = 1'b0;
    begin
      int w;
      w = 0;
      while (frameCount < 5 && w < 20000) begin
        @(negedge clk);
        w++;
      end
    end
    repeat (20) @(negedge clk);
    check(frameCount == 5, "R7 withdrawn op frames", frameCount, 5);
    check(frameOp[4] == 8'h04, "R7 withdrawn op disable", int'(frameOp[4]), 32'h04);
    check(!opAttended && !opFinished, "R10 withdrawn op flags",
          int'({opAttended, opFinished}), 0);

    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

endmodule